// File: doc/BRIEF.md
# Trailing-Edge Low Pulse Extender

This block lengthens an active-low pulse. The input is sampled on a free-running clock. While the input is low, the output is low as well. Once the input returns high, the output stays low for a fixed number of further clock cycles and is then released. The total low time at the output is therefore the input's low time plus a constant extension, and the input's width has no bound.

An extension timer provides the extra time. The rising edge of the input starts it. It counts to the configured length once, then stops and waits for the next trigger. A low input takes priority over everything: it forces the output low and clears the timer.

The output comes straight from a register, so it carries no glitches. The extension length is a parameter. The same structure therefore serves a delay of a couple of cycles and a reset-style hold of tens of milliseconds, where the counter runs to millions of cycles. The input must already be synchronous to `clk`.

Top module: `low_pulse_extender`

## Requirements
- R1: At any clock edge where `pulse_n_i` is sampled low, `pulse_n_o` is low after that edge.
- R2: Suppose `pulse_n_i` is sampled low at edge k and high at every edge from k+1 onward. Then `pulse_n_o` stays low after edges k+1 through k+EXT_CYCLES and goes high after edge k+EXT_CYCLES+1.
- R3: `pulse_n_o` rises only after an edge at which `pulse_n_i` was sampled high and the extension timer had expired.
- R4: Once `pulse_n_o` is high, it stays high for as long as `pulse_n_i` is sampled high. The timer stops at its terminal count and does not run freely.
- R5: A low sample during an extension that is still running clears the timer. The next rising edge of the input then starts a complete new extension, timed as in R2.
- R6: Asserting `rst_n` low drives `pulse_n_o` low at once, without waiting for a clock, and leaves the timer idle. After reset, the first release needs EXT_CYCLES+1 consecutive high samples, just as if the input had been low before reset.
- R7: With EXT_CYCLES = 0, `pulse_n_o` equals the value of `pulse_n_i` sampled at the previous edge.
- R8: The counter width is ceil(log2(EXT_CYCLES+1)), so long extensions (for example 300 cycles, or millions for tens of milliseconds) time exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock that samples the input |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| pulse_n_i | input | 1 | Active-low pulse, synchronous to `clk` |
| pulse_n_o | output | 1 | Registered active-low output, extended by EXT_CYCLES cycles |

## Verification
One input stream drives three instances at once, with extensions of 2, 0 and 300 cycles, and a reference model checks each instance on every cycle. The low periods in the stream range from long to a single cycle. This separates an output that adds the extension to the input width from one that produces a fixed one-shot width. Some high periods are shorter than the extension; these show whether a renewed low clears the timer instead of letting it finish. The final long high period shows whether the timer stops at its limit or keeps running. Directed sequences cover reset with the input held high, a reset that arrives while the output is high, and a retrigger in the middle of an extension.

// File: rtl/pext_pkg.sv
package pext_pkg;

  // Extension timer phases
  typedef enum logic [1:0] {
    TMR_HOLD = 2'd0,   // input low (or just reset): timer cleared
    TMR_RUN  = 2'd1,   // counting extension cycles
    TMR_DONE = 2'd2    // terminal count reached, parked
  } tmr_state_e;

  // Counter width able to hold the value ext (at least one bit)
  function automatic int cnt_width(input int ext);
    return (ext < 1) ? 1 : $clog2(ext + 1);
  endfunction

endpackage

// File: rtl/pext_edge_detect.sv
module pext_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic low_o
);

  logic prev_q;
  logic prev_d;

  // Previous sample resets low, so the first high sample after reset is a start
  always_comb begin
    prev_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise_o = sig_i & ~prev_q;
  assign low_o  = ~sig_i;

  // R5: a start can never be seen on two consecutive edges
  assert_single_start_R5: assert property (
    @(posedge clk) disable iff (!rst_n) rise_o |=> !rise_o
  );

endmodule

// File: rtl/pext_ext_timer.sv
module pext_ext_timer #(
  parameter int EXT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic start_i,
  output logic expired_o
);
  import pext_pkg::*;

  localparam int            CW       = cnt_width(EXT_CYCLES);
  localparam logic [CW-1:0] LAST     = CW'(EXT_CYCLES);
  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam bit            ZERO_EXT = (EXT_CYCLES == 0);

  tmr_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  // Next-state logic: low input clears, rising edge starts, terminal count parks
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (clear_i) begin
      state_d = TMR_HOLD;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        TMR_HOLD: begin
          if (start_i) begin
            if (ZERO_EXT) begin
              state_d = TMR_DONE;
            end else begin
              state_d = TMR_RUN;
              cnt_d   = ONE;
            end
          end
        end
        TMR_RUN: begin
          if (at_last) state_d = TMR_DONE;
          else         cnt_d   = cnt_q + ONE;
        end
        TMR_DONE: begin
          state_d = TMR_DONE;
        end
        default: begin
          state_d = TMR_HOLD;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMR_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign expired_o = (state_q == TMR_DONE)
                   | ((state_q == TMR_RUN) & at_last)
                   | ((state_q == TMR_HOLD) & start_i & ZERO_EXT);

  // R4: the count never passes the configured extension
  assert_cnt_bound_R4: assert property (
    @(posedge clk) disable iff (!rst_n) cnt_q <= LAST
  );

  // R4: once parked, the timer stays parked until cleared
  assert_timer_stops_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
      (state_q == TMR_DONE) && !clear_i |=> (state_q == TMR_DONE)
  );

  // R5: a new extension only begins from the cleared phase
  assert_start_from_hold_R5: assert property (
    @(posedge clk) disable iff (!rst_n) start_i |-> (state_q == TMR_HOLD)
  );

endmodule

// File: rtl/pext_out_latch.sv
module pext_out_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic force_low_i,
  input  logic release_i,
  output logic pulse_n_o
);

  logic out_q, out_d;

  // Set/reset behaviour: low input wins, release sets high, otherwise hold
  always_comb begin
    out_d = out_q;
    if (force_low_i)    out_d = 1'b0;
    else if (release_i) out_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pulse_n_o = out_q;

  // R1: a low request always shows at the output after the edge
  assert_low_follows_R1: assert property (
    @(posedge clk) disable iff (!rst_n) force_low_i |=> !pulse_n_o
  );

  // R2: the output rises only when the timer reported expiry
  assert_rise_needs_expiry_R2: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(pulse_n_o) |-> $past(release_i)
  );

  // R3: the output rises only after a high input sample
  assert_rise_needs_high_R3: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(pulse_n_o) |-> $past(!force_low_i)
  );

endmodule

// File: rtl/low_pulse_extender.sv
module low_pulse_extender #(
  parameter int EXT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_n_i,
  output logic pulse_n_o
);

  logic rise;
  logic low;
  logic expired;
  logic release_hi;

  pext_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (pulse_n_i),
    .rise_o (rise),
    .low_o  (low)
  );

  pext_ext_timer #(.EXT_CYCLES(EXT_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (low),
    .start_i   (rise),
    .expired_o (expired)
  );

  assign release_hi = pulse_n_i & expired;

  pext_out_latch u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_low_i (low),
    .release_i   (release_hi),
    .pulse_n_o   (pulse_n_o)
  );

  // R4: a released output holds while the input stays high
  assert_hold_high_R4: assert property (
    @(posedge clk) disable iff (!rst_n) pulse_n_o && pulse_n_i |=> pulse_n_o
  );

endmodule

// File: tb/sim_low_pulse_extender.sv
`timescale 1ns/1ps
module sim_low_pulse_extender;

  localparam int NDUT = 3;
  localparam int TV [NDUT] = '{2, 0, 300};
  // Stimulus table: bit 16 = input level, bits 15:0 = cycles held
  localparam int NVEC = 12;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 16'd5},  {1'b1, 16'd1},  {1'b0, 16'd1},  {1'b1, 16'd2},
    {1'b0, 16'd3},  {1'b1, 16'd3},  {1'b0, 16'd1},  {1'b1, 16'd10},
    {1'b0, 16'd20}, {1'b1, 16'd2},  {1'b0, 16'd1},  {1'b1, 16'd400}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic din;
  logic [NDUT-1:0] dout;

  int n_checks = 0;
  int n_errors = 0;
  int hs   [NDUT];
  bit expv [NDUT];
  bit prevx[NDUT];

  always #4 clk = ~clk;

  low_pulse_extender #(.EXT_CYCLES(2))   u0 (.clk(clk), .rst_n(rst_n), .pulse_n_i(din), .pulse_n_o(dout[0]));
  low_pulse_extender #(.EXT_CYCLES(0))   u1 (.clk(clk), .rst_n(rst_n), .pulse_n_i(din), .pulse_n_o(dout[1]));
  low_pulse_extender #(.EXT_CYCLES(300)) u2 (.clk(clk), .rst_n(rst_n), .pulse_n_i(din), .pulse_n_o(dout[2]));

  task automatic check(input string tag, input int idx, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: u%0d out=%0b expected %0b at %0t", tag, idx, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NDUT; i++) begin
      hs[i] = 0; expv[i] = 1'b0; prevx[i] = 1'b0;
    end
  endtask

  // One clock: model counts high samples since the last low sample
  task automatic tick(input string force_tag);
    string tag;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NDUT; i++) begin
      prevx[i] = expv[i];
      if (!rst_n || !din) hs[i] = 0;
      else if (hs[i] <= TV[i]) hs[i]++;
      expv[i] = rst_n && din && (hs[i] > TV[i]);
      if (force_tag != "")       tag = force_tag;
      else if (i == 1)           tag = "R7";
      else if (i == 2)           tag = "R8";
      else if (!din)             tag = "R1";
      else if (expv[i] && !prevx[i]) tag = "R3";
      else if (expv[i])          tag = "R4";
      else                       tag = "R2";
      check(tag, i, dout[i], expv[i]);
    end
  endtask

  task automatic hold(input bit lvl, input int n, input string tag);
    din = lvl;
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete, expected end of stimulus");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    model_clear();
    rst_n = 1'b0;
    din   = 1'b0;
    repeat (3) @(negedge clk);
    // R6: reset state with input low and with input high
    for (int i = 0; i < NDUT; i++) check("R6", i, dout[i], 1'b0);
    din = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NDUT; i++) check("R6", i, dout[i], 1'b0);
    // R6: release with input high; u0 needs 3 high samples, u1 one
    rst_n = 1'b1;
    hold(1'b1, 5, "R6");

    // Table walk
    for (int v = 0; v < NVEC; v++) hold(VEC[v][16], int'(VEC[v][15:0]), "");

    // R5: retrigger in the middle of an extension
    hold(1'b0, 3, "R5");
    hold(1'b1, 1, "R5");
    hold(1'b0, 1, "R5");
    hold(1'b1, 2, "R5");
    hold(1'b0, 1, "R5");
    hold(1'b1, 6, "R5");

    // R6: asynchronous reset while the output is high
    hold(1'b1, 300, "");
    #1;
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < NDUT; i++) check("R6", i, dout[i], 1'b0);
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    hold(1'b1, 4, "R6");
    hold(1'b0, 2, "");
    hold(1'b1, 4, "");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule